// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block serves one overlay window of a display pipeline. For every screen pixel it reports whether the pixel lies inside the window's rectangle. For each screen line that crosses the window it issues burst read requests for that line's slice of the framebuffer. The display timing logic provides the screen coordinates and one-cycle frame and line start pulses. Software-visible settings reach the block as static inputs: the two corners, the buffer start and end addresses, the bytes fetched per line, the bytes skipped between lines, a pixel format code and an enable.

A line fetch walks the line's bytes in bursts of whole 32-bit words. The format code sets the burst size. The last burst of the line is cut short so it ends exactly on the line's byte count. The address then jumps over the skip bytes to the first pixel of the next line. A frame start sends the address back to the buffer start. No further requests are made once the address reaches the buffer end. The block also outputs the data swap mode that the unpacking stage downstream should apply for the selected format.

Top module: `ovlFetchGen`

## Requirements
- R1: `inWindow` is high in the same cycle whenever `winEn` is high and tlX <= posX <= brX and tlY <= posY <= brY. Both corners are inclusive. Otherwise `inWindow` is low.
- R2: While `winEn` is low, `inWindow` and `reqValid` are low and no burst is accepted.
- R3: A `lineStart` pulse, taken while idle with `winEn` high and tlY <= posY <= brY, starts a line fetch at the current address. Each accepted burst (`reqValid` and `reqReady` high at a clock edge) advances the address by 4 x `reqLen` bytes. The line ends once `pageWidth` bytes have been requested. A `lineStart` pulse on a line outside the window rows starts nothing.
- R4: `reqLen` (in 32-bit words) is the burst size, or the words left in the line if fewer remain. A line is never overrun.
- R5: After the last burst of a line, the address additionally advances by `skipOffset` bytes.
- R6: `frameStart` reloads the address with `bufStart` and abandons any line in progress. `reqValid` is low in the following cycle.
- R7: No request is issued while the address is greater than or equal to `bufEnd`.
- R8: Format code encoding: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 16 bpp, 5 = 24 bpp, 6 = 32 bpp. The burst size is 4 words for code 0, 8 words for codes 1 to 3, and 16 words for codes 4 to 6.
- R9: `swapMode` encoding: 0 = bit swap (codes 0 to 2), 1 = byte swap (code 3), 2 = halfword swap (code 4), 3 = word swap (codes 5 and 6).
- R10: Code 7, the only code outside the set, behaves as 24 bpp: burst size 16 words and `swapMode` 3.
- R11: While `reqValid` is high and `reqReady` is low, `reqAddr` and `reqLen` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse at start of frame |
| lineStart | input | 1 | One-cycle pulse at start of line |
| posX | input | XW | Current screen column |
| posY | input | XW | Current screen row |
| winEn | input | 1 | Window enable |
| tlX | input | XW | Top-left column (inclusive) |
| tlY | input | XW | Top-left row (inclusive) |
| brX | input | XW | Bottom-right column (inclusive) |
| brY | input | XW | Bottom-right row (inclusive) |
| bufStart | input | AW | Byte address of the window's first pixel |
| bufEnd | input | AW | Byte address at which fetching stops |
| pageWidth | input | PWW | Bytes fetched per line (multiple of 4) |
| skipOffset | input | PWW | Bytes skipped after each line |
| fmtCode | input | 3 | Pixel format code |
| inWindow | output | 1 | Current pixel is inside the window |
| swapMode | output | 2 | Data swap mode for the format |
| reqValid | output | 1 | Burst request valid |
| reqAddr | output | AW | Burst byte address |
| reqLen | output | 5 | Burst length in 32-bit words |
| reqReady | input | 1 | Memory side accepts the request |

## Verification
`inWindow` and `swapMode` are combinational, so the bench checks them half a clock after it drives positions or the format. A request appears one cycle after the `lineStart` edge that the controller accepts. It is consumed at the first rising edge where `reqReady` is also high. The bench therefore compares at falling edges only those cycles in which both `reqValid` and `reqReady` are high, and pops its expected queue in that same cycle. After each line it waits a fixed margin before it checks that the queue is empty, and it checks that `reqValid` is low one cycle after a frame start.

// File: rtl/ovl_fetch_pkg.sv
package ovl_fetch_pkg;
  localparam int BLW = 5;

  typedef enum logic [1:0] {SWAP_BIT = 2'd0, SWAP_BYTE = 2'd1, SWAP_HALF = 2'd2, SWAP_WORD = 2'd3} swapE;

  typedef struct packed {
    logic [BLW-1:0] burstWords;
    swapE           swap;
  } fmtInfoT;

  typedef struct packed {
    logic loadStart;
    logic lineStart;
    logic advance;
  } ctrlStrobeT;

  function automatic fmtInfoT decodeFmt(input logic [2:0] code);
    fmtInfoT f;
    case (code)
      3'd0:    begin f.burstWords = 5'd4;  f.swap = SWAP_BIT;  end
      3'd1,
      3'd2:    begin f.burstWords = 5'd8;  f.swap = SWAP_BIT;  end
      3'd3:    begin f.burstWords = 5'd8;  f.swap = SWAP_BYTE; end
      3'd4:    begin f.burstWords = 5'd16; f.swap = SWAP_HALF; end
      default: begin f.burstWords = 5'd16; f.swap = SWAP_WORD; end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/ovlFetchPath.sv
module ovlFetchPath
  import ovl_fetch_pkg::*;
#(
  parameter int XW  = 12,
  parameter int AW  = 32,
  parameter int PWW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [XW-1:0]    posX,
  input  logic [XW-1:0]    posY,
  input  logic             winEn,
  input  logic [XW-1:0]    tlX,
  input  logic [XW-1:0]    tlY,
  input  logic [XW-1:0]    brX,
  input  logic [XW-1:0]    brY,
  input  logic [AW-1:0]    bufStart,
  input  logic [AW-1:0]    bufEnd,
  input  logic [PWW-1:0]   pageWidth,
  input  logic [PWW-1:0]   skipOffset,
  input  logic [BLW-1:0]   burstWords,
  output logic             inWindow,
  output logic             yInWin,
  output logic             atEnd,
  output logic             remZero,
  output logic             lastBurst,
  output logic [AW-1:0]    curAddr,
  output logic [BLW-1:0]   lenWords
);
  localparam int RWW = PWW - 2;

  logic [PWW-1:0] remBytes;
  logic [RWW-1:0] remWords;
  logic [RWW-1:0] burstExt;
  logic [AW-1:0]  lenBytesA;
  logic [PWW-1:0] lenBytesP;
  logic [AW-1:0]  skipA;
  logic           xInWin;

  assign xInWin   = (posX >= tlX) && (posX <= brX);
  assign yInWin   = (posY >= tlY) && (posY <= brY);
  assign inWindow = winEn && xInWin && yInWin;

  assign remWords  = remBytes[PWW-1:2];
  assign burstExt  = {{(RWW-BLW){1'b0}}, burstWords};
  assign lastBurst = (remWords <= burstExt);
  assign lenWords  = lastBurst ? remWords[BLW-1:0] : burstWords;
  assign remZero   = (remWords == '0);
  assign atEnd     = (curAddr >= bufEnd);

  assign lenBytesA = {{(AW-BLW-2){1'b0}}, lenWords, 2'b00};
  assign lenBytesP = {{(PWW-BLW-2){1'b0}}, lenWords, 2'b00};
  assign skipA     = {{(AW-PWW){1'b0}}, skipOffset};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
    end else if (strobe.loadStart) begin
      curAddr  <= bufStart;
      remBytes <= '0;
    end else begin
      if (strobe.lineStart) remBytes <= pageWidth;
      if (strobe.advance) begin
        curAddr  <= curAddr + lenBytesA + (lastBurst ? skipA : '0);
        remBytes <= remBytes - lenBytesP;
      end
    end
  end
endmodule

// File: rtl/ovlFetchCtrl.sv
module ovlFetchCtrl
  import ovl_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       lineStart,
  input  logic       winEn,
  input  logic       yInWin,
  input  logic       atEnd,
  input  logic       remZero,
  input  logic       lastBurst,
  input  logic       reqReady,
  output logic       reqValid,
  output ctrlStrobeT strobe
);
  typedef enum logic {ST_IDLE, ST_FETCH} stateE;
  stateE state, nextState;
  logic  fire;

  assign reqValid = (state == ST_FETCH) && winEn && !atEnd && !remZero;
  assign fire     = reqValid && reqReady;

  always_comb begin
    strobe.loadStart = frameStart;
    strobe.lineStart = !frameStart && (state == ST_IDLE) && lineStart && winEn && yInWin;
    strobe.advance   = !frameStart && fire;
  end

  always_comb begin
    nextState = state;
    if (frameStart) nextState = ST_IDLE;
    else if (state == ST_IDLE) begin
      if (strobe.lineStart) nextState = ST_FETCH;
    end else if (!winEn || atEnd || remZero || (fire && lastBurst)) begin
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ovlFetchGen.sv
module ovlFetchGen
  import ovl_fetch_pkg::*;
#(
  parameter int XW  = 12,
  parameter int AW  = 32,
  parameter int PWW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           frameStart,
  input  logic           lineStart,
  input  logic [XW-1:0]  posX,
  input  logic [XW-1:0]  posY,
  input  logic           winEn,
  input  logic [XW-1:0]  tlX,
  input  logic [XW-1:0]  tlY,
  input  logic [XW-1:0]  brX,
  input  logic [XW-1:0]  brY,
  input  logic [AW-1:0]  bufStart,
  input  logic [AW-1:0]  bufEnd,
  input  logic [PWW-1:0] pageWidth,
  input  logic [PWW-1:0] skipOffset,
  input  logic [2:0]     fmtCode,
  output logic           inWindow,
  output logic [1:0]     swapMode,
  output logic           reqValid,
  output logic [AW-1:0]  reqAddr,
  output logic [4:0]     reqLen,
  input  logic           reqReady
);
  fmtInfoT    fmt;
  ctrlStrobeT strobe;
  logic       yInWin, atEnd, remZero, lastBurst;

  assign fmt      = decodeFmt(fmtCode);
  assign swapMode = fmt.swap;

  ovlFetchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .winEn(winEn), .yInWin(yInWin), .atEnd(atEnd), .remZero(remZero),
    .lastBurst(lastBurst), .reqReady(reqReady), .reqValid(reqValid), .strobe(strobe)
  );

  ovlFetchPath #(.XW(XW), .AW(AW), .PWW(PWW)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .posX(posX), .posY(posY),
    .winEn(winEn), .tlX(tlX), .tlY(tlY), .brX(brX), .brY(brY),
    .bufStart(bufStart), .bufEnd(bufEnd), .pageWidth(pageWidth),
    .skipOffset(skipOffset), .burstWords(fmt.burstWords), .inWindow(inWindow),
    .yInWin(yInWin), .atEnd(atEnd), .remZero(remZero), .lastBurst(lastBurst),
    .curAddr(reqAddr), .lenWords(reqLen)
  );
endmodule

// File: rtl/ovlFetchChk.sv
module ovlFetchChk
  import ovl_fetch_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic          winEn,
  input logic [2:0]    fmtCode,
  input logic [AW-1:0] bufEnd,
  input logic          inWindow,
  input logic          reqValid,
  input logic          reqReady,
  input logic [AW-1:0] reqAddr,
  input logic [4:0]    reqLen
);
  fmtInfoT fmtRef;
  assign fmtRef = decodeFmt(fmtCode);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !winEn |-> (!inWindow && !reqValid)); // R2

  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != 5'd0 && reqLen <= fmtRef.burstWords)); // R4

  AST_FRAME_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !reqValid); // R6

  AST_BELOW_END: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr < bufEnd)); // R7

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !frameStart) |=> (!reqValid || ($stable(reqAddr) && $stable(reqLen)))); // R11
endmodule

bind ovlFetchGen ovlFetchChk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .winEn(winEn),
  .fmtCode(fmtCode), .bufEnd(bufEnd), .inWindow(inWindow),
  .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen)
);

// File: tb/tb_ovlFetchGen.sv
`timescale 1ns/1ps
module tb_ovlFetchGen;
  localparam int XW = 12, AW = 32, PWW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 0, lineStart = 0, winEn = 0, reqReady = 0;
  logic [XW-1:0] posX = 0, posY = 0, tlX = 0, tlY = 0, brX = 0, brY = 0;
  logic [AW-1:0] bufStart = 0, bufEnd = 0;
  logic [PWW-1:0] pageWidth = 0, skipOffset = 0;
  logic [2:0] fmtCode = 0;
  logic inWindow, reqValid;
  logic [1:0] swapMode;
  logic [AW-1:0] reqAddr;
  logic [4:0] reqLen;

  int checks = 0, fails = 0, cyc = 0;
  logic holdReady = 0;
  logic [AW+4:0] expQ[$];
  logic [AW-1:0] mCur = 0;

  always #2.5 clk = ~clk;

  ovlFetchGen #(.XW(XW), .AW(AW), .PWW(PWW)) dut (.*);

  function automatic int bwOf(input logic [2:0] c);
    if (c == 3'd0) return 4;
    if (c <= 3'd3) return 8;
    return 16;
  endfunction
  function automatic int swOf(input logic [2:0] c);
    if (c <= 3'd2) return 0;
    if (c == 3'd3) return 1;
    if (c == 3'd4) return 2;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    reqReady <= !holdReady && ((cyc % 3) != 1);
  end

  // monitor: compare each accepted burst with the scoreboard
  always @(negedge clk) begin
    #1;
    if (rstN && reqValid && reqReady) begin
      if (expQ.size() == 0) check(0, "R3/R7 unexpected burst", longint'(reqAddr), 0);
      else begin
        logic [AW+4:0] e;
        e = expQ.pop_front();
        check(reqAddr == e[AW+4:5], "R3/R5 burst address", longint'(reqAddr), longint'(e[AW+4:5]));
        check(reqLen == e[4:0], "R4/R8 burst length", longint'(reqLen), longint'(e[4:0]));
      end
    end
  end

  task automatic doFrame();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    mCur = bufStart;
    expQ.delete();
  endtask

  task automatic doLine(input int y, input int waitCyc);
    int rem, bw, len;
    posY = XW'(y);
    if (winEn && y >= tlY && y <= brY) begin
      rem = int'(pageWidth) / 4;
      bw = bwOf(fmtCode);
      while (rem > 0 && mCur < bufEnd) begin
        len = (rem < bw) ? rem : bw;
        expQ.push_back({mCur, 5'(len)});
        mCur += AW'(len * 4);
        rem -= len;
        if (rem == 0) mCur += AW'(skipOffset);
      end
    end
    @(negedge clk); lineStart = 1;
    @(negedge clk); lineStart = 0;
    repeat (waitCyc) @(negedge clk);
    check(expQ.size() == 0, "R3 line bursts delivered", expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(reqValid == 0, "R2 reset reqValid", reqValid, 0);
    check(inWindow == 0, "R2 reset inWindow", inWindow, 0);
    rstN = 1;
    tlX = 10; tlY = 5; brX = 59; brY = 8;
    bufStart = 32'h1000; bufEnd = 32'h1180;
    pageWidth = 100; skipOffset = 28; fmtCode = 4; winEn = 1;

    // R1 inclusive corners
    @(negedge clk); posX = 10; posY = 5; #1 check(inWindow == 1, "R1 top-left", inWindow, 1);
    @(negedge clk); posX = 59; posY = 8; #1 check(inWindow == 1, "R1 bottom-right", inWindow, 1);
    @(negedge clk); posX = 9;  posY = 6; #1 check(inWindow == 0, "R1 left of window", inWindow, 0);
    @(negedge clk); posX = 60; posY = 6; #1 check(inWindow == 0, "R1 right of window", inWindow, 0);
    @(negedge clk); posX = 30; posY = 4; #1 check(inWindow == 0, "R1 above window", inWindow, 0);
    @(negedge clk); posX = 30; posY = 9; #1 check(inWindow == 0, "R1 below window", inWindow, 0);

    // R3 R4 R5 R7: rows 4..8, buffer holds three lines
    doFrame();
    for (int y = 4; y <= 8; y++) doLine(y, 40);

    // R8 R9 R10 format sweep
    for (int f = 0; f < 8; f++) begin
      fmtCode = 3'(f);
      #1 check(swapMode == 2'(swOf(3'(f))), (f == 7) ? "R10 swap for code 7" : "R9 swap mode",
               swapMode, swOf(3'(f)));
      doFrame();
      doLine(5, 80);
    end

    // R6 frame start abandons a stalled line
    fmtCode = 4; holdReady = 1;
    doFrame();
    posY = 5;
    @(negedge clk); lineStart = 1;
    @(negedge clk); lineStart = 0;
    #1 check(reqValid == 1, "R11 request pending while stalled", reqValid, 1);
    check(reqAddr == 32'h1000, "R11 stalled address", longint'(reqAddr), 32'h1000);
    @(negedge clk); #1 check(reqAddr == 32'h1000 && reqLen == 16, "R11 hold while stalled", longint'(reqAddr), 32'h1000);
    doFrame();
    #1 check(reqValid == 0, "R6 idle after frame start", reqValid, 0);
    holdReady = 0;
    doLine(5, 40);

    // R2 disabled window
    winEn = 0; posX = 30; posY = 6;
    #1 check(inWindow == 0, "R2 disabled inWindow", inWindow, 0);
    doFrame();
    doLine(6, 30);
    #1 check(reqValid == 0, "R2 disabled no request", reqValid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule